// File: doc/BRIEF.md
# Saturating Ternary Bridge-State Controller

This block keeps the switching state of three full-bridge cells, one per phase, in the medium-voltage stage of a cascaded multilevel inverter. Each cell sits at one of three levels: negative, zero or positive. The level is stored as a 2-bit code whose two bits drive the two bridge arms directly, so no decoding stage follows. In every sampling cycle the block reads six domain-exceed flags. Each flag asks for one phase's difference from the other two phases to rise or to fall. The block serves one flag and moves the state by a single step. Each level stays within its range, and a request it cannot carry out leaves the state unchanged.

A request for a phase is first tried on that phase alone. If that would push the phase out of range, the block moves the other two phases one step the opposite way, which changes the requested difference pair in the same direction. If that is also out of range, the state is held. The zero level has two codes. The block alternates between them on successive entries to zero, which spreads conduction across the devices. The block also outputs the residual reference: the incoming reference, in 60-degree displaced coordinates, minus the vector that the present state produces. The next lower stage uses this residual.

Top module: `tern_stage_ctrl`

## Requirements
- R1: After reset every phase is at level 1 with code 00, and each residual output equals its reference input.
- R2: The per-phase codes are: level 0 (negative) is 01, level 2 (positive) is 10, and level 1 (zero) is 00 or 11. Phase A uses bits [1:0] of phaseCodes, B uses [3:2] and C uses [5:4].
- R3: Flag bit 2p requests an increase of phase p and bit 2p+1 requests a decrease (p: A=0, B=1, C=2). If the named phase can move one step in the requested direction within 0..2, only that phase moves, in the next cycle.
- R4: If the named phase cannot move but both other phases can move one step in the opposite direction, those two phases move and the named phase stays.
- R5: If neither of those moves fits within 0..2, all three codes are held.
- R6: With no flag set, all codes are held.
- R7: When several flags are set, only the lowest-indexed set flag is served.
- R8: Each phase uses zero code 11 on its first entry to level 1 after reset. It alternates between 11 and 00 on each later entry.
- R9: resG = refG - 3*(lvlA - lvlB) and resH = refH - 3*(lvlB - lvlC), computed from the present levels and the present reference, as signed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| exceedFlags | input | 6 | Domain-exceed requests, inc/dec per phase |
| refG | input | 8 | Signed reference, G coordinate |
| refH | input | 8 | Signed reference, H coordinate |
| phaseCodes | output | 6 | Arm-drive codes {C, B, A} |
| resG | output | 11 | Signed residual, G coordinate |
| resH | output | 11 | Signed residual, H coordinate |

## Verification
A directed sequence walks one phase into both saturation corners. This shows the single-phase step apart from the opposite-direction fallback on the other two phases, and both apart from the full hold. Simultaneous flags with a different winner in each case separate the lowest-index rule from any other ordering. Repeated entries of a phase into zero expose whether the zero code alternates or stays fixed. A long pseudo-random flag and reference stream is then compared against a level model, which also checks the residual arithmetic across all reachable states.

// File: rtl/tern_pkg.sv
package tern_pkg;
  parameter int NPH = 3;
  typedef struct packed {
    logic [NPH-1:0] up;
    logic [NPH-1:0] down;
  } stepCmd_t;
endpackage

// File: rtl/tern_ctrl.sv
module tern_ctrl
  import tern_pkg::*;
(
  input  logic [2*NPH-1:0]      exceedFlags,
  input  logic [NPH-1:0][1:0]   lvl,
  output stepCmd_t              cmd
);
  logic found;
  logic isInc;
  int   ph;
  logic canSelf;
  logic canOthers;

  always_comb begin
    found = 1'b0;
    isInc = 1'b0;
    ph    = 0;
    for (int k = 0; k < 2*NPH; k++) begin
      if (!found && exceedFlags[k]) begin
        found = 1'b1;
        ph    = k / 2;
        isInc = (k % 2) == 0;
      end
    end
    canSelf   = isInc ? (lvl[ph] != 2'd2) : (lvl[ph] != 2'd0);
    canOthers = 1'b1;
    for (int q = 0; q < NPH; q++) begin
      if (q != ph) begin
        if (isInc) canOthers = canOthers & (lvl[q] != 2'd0);
        else       canOthers = canOthers & (lvl[q] != 2'd2);
      end
    end
    cmd = '0;
    if (found) begin
      if (canSelf) begin
        if (isInc) cmd.up[ph]   = 1'b1;
        else       cmd.down[ph] = 1'b1;
      end else if (canOthers) begin
        for (int q = 0; q < NPH; q++) begin
          if (q != ph) begin
            if (isInc) cmd.down[q] = 1'b1;
            else       cmd.up[q]   = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tern_dp.sv
module tern_dp
  import tern_pkg::*;
#(
  parameter int W    = 8,
  parameter int STEP = 3,
  localparam int RW  = W + 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stepCmd_t             cmd,
  input  logic signed [W-1:0]  refG,
  input  logic signed [W-1:0]  refH,
  output logic [NPH-1:0][1:0]  codes,
  output logic [NPH-1:0][1:0]  lvl,
  output logic signed [RW-1:0] resG,
  output logic signed [RW-1:0] resH
);
  localparam logic signed [RW-1:0] STEPW = RW'(STEP);

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic [1:0] codeQ;
    logic       nextZeroHigh;
    logic [1:0] curLvl;
    logic [1:0] nxtLvl;

    always_comb begin
      case (codeQ)
        2'b01:   curLvl = 2'd0;
        2'b10:   curLvl = 2'd2;
        default: curLvl = 2'd1;
      endcase
      nxtLvl = curLvl + {1'b0, cmd.up[p]} - {1'b0, cmd.down[p]};
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        codeQ        <= 2'b00;
        nextZeroHigh <= 1'b1;
      end else if (cmd.up[p] || cmd.down[p]) begin
        case (nxtLvl)
          2'd0: codeQ <= 2'b01;
          2'd2: codeQ <= 2'b10;
          default: begin
            codeQ        <= {2{nextZeroHigh}};
            nextZeroHigh <= ~nextZeroHigh;
          end
        endcase
      end
    end

    assign codes[p] = codeQ;
    assign lvl[p]   = curLvl;
  end

  logic signed [RW-1:0] lvlS [NPH];
  for (genvar p = 0; p < NPH; p++) begin : g_ext
    assign lvlS[p] = $signed({{(RW-2){1'b0}}, lvl[p]});
  end

  logic signed [RW-1:0] refGx, refHx;
  assign refGx = {{(RW-W){refG[W-1]}}, refG};
  assign refHx = {{(RW-W){refH[W-1]}}, refH};
  assign resG  = refGx - STEPW * (lvlS[0] - lvlS[1]);
  assign resH  = refHx - STEPW * (lvlS[1] - lvlS[2]);
endmodule

// File: rtl/tern_stage_ctrl.sv
module tern_stage_ctrl
  import tern_pkg::*;
#(
  parameter int W    = 8,
  parameter int STEP = 3,
  localparam int RW  = W + 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [5:0]           exceedFlags,
  input  logic signed [W-1:0]  refG,
  input  logic signed [W-1:0]  refH,
  output logic [5:0]           phaseCodes,
  output logic signed [RW-1:0] resG,
  output logic signed [RW-1:0] resH
);
  stepCmd_t             cmd;
  logic [NPH-1:0][1:0]  lvl;
  logic [NPH-1:0][1:0]  codes;

  tern_ctrl u_ctrl (
    .exceedFlags (exceedFlags),
    .lvl         (lvl),
    .cmd         (cmd)
  );

  tern_dp #(.W(W), .STEP(STEP)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .refG  (refG),
    .refH  (refH),
    .codes (codes),
    .lvl   (lvl),
    .resG  (resG),
    .resH  (resH)
  );

  assign phaseCodes = codes;
endmodule

// File: rtl/tern_stage_chk.sv
module tern_stage_chk #(
  parameter int W    = 8,
  parameter int STEP = 3,
  localparam int RW  = W + 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [5:0]           exceedFlags,
  input logic signed [W-1:0]  refG,
  input logic signed [W-1:0]  refH,
  input logic [5:0]           phaseCodes,
  input logic signed [RW-1:0] resG,
  input logic signed [RW-1:0] resH
);
  function automatic int lvlOf(input logic [1:0] c);
    return (c == 2'b01) ? 0 : (c == 2'b10) ? 2 : 1;
  endfunction

  int lA, lB, lC;
  assign lA = lvlOf(phaseCodes[1:0]);
  assign lB = lvlOf(phaseCodes[3:2]);
  assign lC = lvlOf(phaseCodes[5:4]);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    exceedFlags == 6'b0 |=> $stable(phaseCodes));

  // R3
  step_up_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    exceedFlags[0] && lA < 2 |=> lA == $past(lA) + 1);

  // R5
  saturate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    exceedFlags[0] && lA == 2 && (lB == 0 || lC == 0) |=> $stable(phaseCodes));

  // R4
  fallback_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    exceedFlags[0] && lA == 2 && lB > 0 && lC > 0
    |=> lB == $past(lB) - 1 && lC == $past(lC) - 1 && lA == 2);

  // R9
  residual_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(resG) == int'(refG) - STEP*(lA - lB)) && (int'(resH) == int'(refH) - STEP*(lB - lC)));
endmodule

bind tern_stage_ctrl tern_stage_chk #(.W(W), .STEP(STEP)) u_chk (
  .clk(clk), .rstN(rstN), .exceedFlags(exceedFlags), .refG(refG), .refH(refH),
  .phaseCodes(phaseCodes), .resG(resG), .resH(resH)
);

// File: tb/tern_stage_ctrl_bench.sv
module tern_stage_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int W = 8;
  localparam int STEP = 3;
  localparam int RW = W + 3;

  logic clk = 0;
  logic rstN = 0;
  logic [5:0] exceedFlags = '0;
  logic signed [W-1:0] refG = '0, refH = '0;
  logic [5:0] phaseCodes;
  logic signed [RW-1:0] resG, resH;

  always #(CLK_P/2) clk = ~clk;

  tern_stage_ctrl #(.W(W), .STEP(STEP)) u_tern_stage_ctrl (
    .clk(clk), .rstN(rstN), .exceedFlags(exceedFlags), .refG(refG), .refH(refH),
    .phaseCodes(phaseCodes), .resG(resG), .resH(resH));

  typedef struct {
    logic [5:0] codes;
    int g;
    int h;
    string tag;
  } expItem_t;

  expItem_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  int mLvl[3];
  bit mZeroHigh[3];
  logic [1:0] mCode[3];

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Level model built from R2..R8
  task automatic modelStep(input logic [5:0] f);
    int k, ph, nl[3];
    bit inc, okSelf, okOth;
    k = -1;
    for (int i = 5; i >= 0; i--) if (f[i]) k = i;
    for (int i = 0; i < 3; i++) nl[i] = mLvl[i];
    if (k >= 0) begin
      ph = k / 2;
      inc = (k % 2) == 0;
      okSelf = inc ? mLvl[ph] < 2 : mLvl[ph] > 0;
      okOth = 1;
      for (int i = 0; i < 3; i++)
        if (i != ph) okOth = okOth && (inc ? mLvl[i] > 0 : mLvl[i] < 2);
      if (okSelf) nl[ph] = mLvl[ph] + (inc ? 1 : -1);
      else if (okOth)
        for (int i = 0; i < 3; i++) if (i != ph) nl[i] = mLvl[i] + (inc ? -1 : 1);
    end
    for (int i = 0; i < 3; i++) begin
      if (nl[i] != mLvl[i]) begin
        if (nl[i] == 0) mCode[i] = 2'b01;
        else if (nl[i] == 2) mCode[i] = 2'b10;
        else begin
          mCode[i] = mZeroHigh[i] ? 2'b11 : 2'b00;
          mZeroHigh[i] = !mZeroHigh[i];
        end
      end
      mLvl[i] = nl[i];
    end
  endtask

  task automatic drive(input logic [5:0] f, input int g, input int h, input string tag);
    expItem_t e;
    @(negedge clk);
    exceedFlags = f;
    refG = W'(g);
    refH = W'(h);
    modelStep(f);
    e.codes = {mCode[2], mCode[1], mCode[0]};
    e.g = g - STEP * (mLvl[0] - mLvl[1]);
    e.h = h - STEP * (mLvl[1] - mLvl[2]);
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    expItem_t e;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.tag, " codes"}, int'(phaseCodes), int'(e.codes));
        check({e.tag, " R9 resG"}, int'(resG), e.g);
        check({e.tag, " R9 resH"}, int'(resH), e.h);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin : stim
    logic [15:0] lfsr;
    for (int i = 0; i < 3; i++) begin
      mLvl[i] = 1;
      mZeroHigh[i] = 1;
      mCode[i] = 2'b00;
    end
    refG = 8'sd7;
    refH = -8'sd5;
    repeat (3) @(negedge clk);
    rstN = 1;
    #(CLK_P/4);
    // R1 reset state
    check("R1 codes", int'(phaseCodes), 0);
    check("R1 resG", int'(resG), 7);
    check("R1 resH", int'(resH), -5);

    drive(6'b000000, 7, -5, "R6 idle");
    drive(6'b000001, 10, 3, "R3 incA to 2");
    drive(6'b000001, -4, 9, "R4 incA fallback B,C down");
    drive(6'b000001, 1, 1, "R5 incA saturated hold");
    drive(6'b001000, 2, -2, "R5 decB saturated hold");
    drive(6'b100100, 0, 0, "R7 incB wins over decC, R8 B first zero 11");
    drive(6'b000010, 5, 5, "R3 R8 decA first zero 11");
    drive(6'b000010, -6, 4, "R3 decA to 0");
    drive(6'b000011, 3, -3, "R7 incA wins, R8 A second zero 00");
    drive(6'b100000, 8, -8, "R4 decC fallback A,B up");
    drive(6'b000000, -20, 20, "R6 idle after fallback");

    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      logic [5:0] f;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      f = (lfsr[3:0] == 4'd0) ? 6'b0 : lfsr[9:4];
      drive(f, int'($signed(lfsr[15:10])), int'($signed(lfsr[7:2])), "R2 R3 R4 R5 R7 R8 mixed stream");
    end
    @(negedge clk);
    exceedFlags = '0;
    repeat (3) @(negedge clk);
    finish();
  end
endmodule